// File: doc/BRIEF.md
# SCSI Initiator Command and Interrupt Unit

This block is the register-level front end of a SCSI initiator controller. A host writes bytes into a write-side register bank and reads a separate read-side bank. The read bank holds the bus-phase status, the interrupt cause and the sequence step. Writing the command register decodes an opcode and updates the read bank in the same clock edge. Commands that complete a bus step also set the pending bit of a 32-bit DMA control register and raise a level interrupt.

The host clears the interrupt by writing the DMA control register with its enable bit (bit 4) low. Device presence per target slot is given as an input vector. No bus signalling or memory traffic is modelled. The transfer count assembled from the write bank is exposed so that a DMA engine can use it.

Top module: `scsi_cmd_unit`

## Requirements
- R1: After reset every read register is 0x00 except address 0xE, which reads 0x04. dma_ctrl is 0 and irq is low.
- R2: A host write never changes the read bank. xfer_count equals {write reg 1, write reg 0}. The target ID is bits [2:0] of write reg 4.
- R3: A write to address 3 issues a command whose opcode is bits [6:0] of the data. Bit 7 has no effect.
- R4: Opcode 0x42 or 0x43 to a present target with ID at most 4 gives status (addr 4) 0x91, interrupt cause (addr 5) 0x18 and step (addr 6) 0x04.
- R5: Opcode 0x42 or 0x43 to a target with ID above 4, or to a slot whose present bit is 0, gives status 0x80, cause 0x20 and step 0x00.
- R6: Opcode 0x10 (transfer information) gives status 0x93, cause 0x10 and step 0x00.
- R7: Opcode 0x11 gives status 0x93, cause 0x18 and step 0x04. Opcode 0x12 gives status 0x93, cause 0x20 and step 0x00.
- R8: Each command of R4 to R7 sets dma_ctrl bit 0 and drives irq high from the next clock. No other command raises irq.
- R9: A DMA control write loads dma_ctrl with the written word. If bit 4 of that word is 0, irq goes low. If bit 4 is 1, irq keeps its level.
- R10: Opcode 0x01 (flush) sets cause 0x08 and step 0x00, keeps the status and leaves irq unchanged.
- R11: Opcodes 0x00, 0x03 and 0x1A, and any undefined opcode, change no read register, dma_ctrl or irq.
- R12: Opcode 0x02 (chip reset) returns the read bank and dma_ctrl to the R1 values and leaves irq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 4 | Write-bank address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read-bank address |
| rd_data | output | 8 | Read-bank byte at rd_addr (combinational) |
| dev_present | input | 8 | Per-slot device present flags |
| dma_wr_en | input | 1 | DMA control register write strobe |
| dma_wr_data | input | 32 | DMA control write word |
| dma_ctrl | output | 32 | DMA control register |
| xfer_count | output | 16 | Transfer count from the write bank |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that a command write and a DMA control write never land in the same cycle. When they collide, the raise and the clear race, and the clear checks would not hold. The assertions also take for granted that dev_present stays steady around a select command. The stimulus issues every DMA write in its own cycle, apart from any command write. It holds dev_present at one constant mask, and that mask includes a present flag for slot 5 so that the ID-above-4 rule is exercised.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

    localparam int REG_ADDR_W = 4;
    localparam int REG_DATA_W = 8;
    localparam int REG_COUNT  = 1 << REG_ADDR_W;
    localparam int CTRL_W     = 32;

    // Write-bank addresses
    localparam logic [REG_ADDR_W-1:0] W_CNT_LO = 4'h0;
    localparam logic [REG_ADDR_W-1:0] W_CNT_HI = 4'h1;
    localparam logic [REG_ADDR_W-1:0] W_CMD    = 4'h3;
    localparam logic [REG_ADDR_W-1:0] W_TARGET = 4'h4;

    // Read-bank addresses
    localparam logic [REG_ADDR_W-1:0] R_STAT  = 4'h4;
    localparam logic [REG_ADDR_W-1:0] R_CAUSE = 4'h5;
    localparam logic [REG_ADDR_W-1:0] R_STEP  = 4'h6;
    localparam logic [REG_ADDR_W-1:0] R_REV   = 4'hE;
    localparam logic [REG_DATA_W-1:0] REV_CODE = 8'h04;

    typedef enum logic [6:0] {
        OP_NOP      = 7'h00,
        OP_FLUSH    = 7'h01,
        OP_CHIP_RST = 7'h02,
        OP_BUS_RST  = 7'h03,
        OP_XFER     = 7'h10,
        OP_CMPL_SEQ = 7'h11,
        OP_MSG_ACC  = 7'h12,
        OP_SET_ATN  = 7'h1A,
        OP_SEL_ATN  = 7'h42,
        OP_SEL_STOP = 7'h43
    } opcode_e;

    // Bus phase codes in the low status bits
    localparam logic [2:0] PH_DATA_OUT = 3'd0;
    localparam logic [2:0] PH_DATA_IN  = 3'd1;
    localparam logic [2:0] PH_COMMAND  = 3'd2;
    localparam logic [2:0] PH_STATUS   = 3'd3;
    localparam logic [2:0] PH_MSG_IN   = 3'd6;
    localparam logic [2:0] PH_MSG_OUT  = 3'd7;

    localparam logic [7:0] ST_TCOUNT  = 8'h10;
    localparam logic [7:0] ST_PENDING = 8'h80;

    localparam logic [7:0] IC_FUNC_DONE = 8'h08;
    localparam logic [7:0] IC_BUS_SVC   = 8'h10;
    localparam logic [7:0] IC_DISCONN   = 8'h20;

    localparam logic [7:0] STEP_IDLE    = 8'h00;
    localparam logic [7:0] STEP_CMD_END = 8'h04;

    localparam int DMA_PEND_BIT = 0;
    localparam int DMA_IEN_BIT  = 4;

    typedef struct packed {
        logic       load_stat;
        logic       load_cause;
        logic       wipe;
        logic       raise;
        logic [7:0] stat;
        logic [7:0] cause;
        logic [7:0] step;
    } outcome_t;

    function automatic outcome_t no_outcome();
        outcome_t o;
        o = '0;
        return o;
    endfunction

    function automatic logic [7:0] status_byte(input logic [2:0] phase);
        return ST_PENDING | ST_TCOUNT | {5'b0, phase};
    endfunction

endpackage

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder
    import scsi_cmd_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int MAX_TARGET = 4
) (
    input  logic                 fire,
    input  logic [6:0]           op,
    input  logic [2:0]           target,
    input  logic [NUM_SLOTS-1:0] present,
    output outcome_t             outcome
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic target_ok;

    always_comb begin
        target_ok = 1'b0;
        if (int'(target) <= MAX_TARGET && int'(target) < NUM_SLOTS)
            target_ok = present[SLOT_W'(target)];
    end

    always_comb begin
        outcome = no_outcome();
        if (fire) begin
            case (op)
                OP_FLUSH: begin
                    outcome.load_cause = 1'b1;
                    outcome.cause      = IC_FUNC_DONE;
                    outcome.step       = STEP_IDLE;
                end
                OP_CHIP_RST: outcome.wipe = 1'b1;
                OP_XFER: begin
                    outcome.load_stat  = 1'b1;
                    outcome.load_cause = 1'b1;
                    outcome.raise      = 1'b1;
                    outcome.stat       = status_byte(PH_STATUS);
                    outcome.cause      = IC_BUS_SVC;
                    outcome.step       = STEP_IDLE;
                end
                OP_CMPL_SEQ: begin
                    outcome.load_stat  = 1'b1;
                    outcome.load_cause = 1'b1;
                    outcome.raise      = 1'b1;
                    outcome.stat       = status_byte(PH_STATUS);
                    outcome.cause      = IC_BUS_SVC | IC_FUNC_DONE;
                    outcome.step       = STEP_CMD_END;
                end
                OP_MSG_ACC: begin
                    outcome.load_stat  = 1'b1;
                    outcome.load_cause = 1'b1;
                    outcome.raise      = 1'b1;
                    outcome.stat       = status_byte(PH_STATUS);
                    outcome.cause      = IC_DISCONN;
                    outcome.step       = STEP_IDLE;
                end
                OP_SEL_ATN, OP_SEL_STOP: begin
                    outcome.load_stat  = 1'b1;
                    outcome.load_cause = 1'b1;
                    outcome.raise      = 1'b1;
                    if (target_ok) begin
                        outcome.stat  = status_byte(PH_DATA_IN);
                        outcome.cause = IC_BUS_SVC | IC_FUNC_DONE;
                        outcome.step  = STEP_CMD_END;
                    end else begin
                        outcome.stat  = ST_PENDING;
                        outcome.cause = IC_DISCONN;
                        outcome.step  = STEP_IDLE;
                    end
                end
                default: outcome = no_outcome();
            endcase
        end
    end
endmodule

// File: rtl/scsi_write_bank.sv
module scsi_write_bank
    import scsi_cmd_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W,
    parameter int DATA_W = REG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_fire,
    output logic [6:0]        cmd_op,
    output logic [2:0]        target,
    output logic [2*DATA_W-1:0] xfer_count
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
                regs[i] <= wr_data;
        end
    end

    assign cmd_fire   = wr_en && (wr_addr == W_CMD);
    assign cmd_op     = wr_data[6:0];
    assign target     = regs[W_TARGET][2:0];
    assign xfer_count = {regs[W_CNT_HI], regs[W_CNT_LO]};
endmodule

// File: rtl/scsi_read_bank.sv
module scsi_read_bank
    import scsi_cmd_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W,
    parameter int DATA_W = REG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  outcome_t          outcome,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] cause_q,
    output logic [DATA_W-1:0] step_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        localparam logic [DATA_W-1:0] INIT =
            (ADDR_W'(i) == R_REV) ? DATA_W'(REV_CODE) : '0;
        always_ff @(posedge clk) begin
            if (rst || outcome.wipe)
                regs[i] <= INIT;
            else if (ADDR_W'(i) == R_STAT && outcome.load_stat)
                regs[i] <= DATA_W'(outcome.stat);
            else if (ADDR_W'(i) == R_CAUSE && outcome.load_cause)
                regs[i] <= DATA_W'(outcome.cause);
            else if (ADDR_W'(i) == R_STEP && outcome.load_cause)
                regs[i] <= DATA_W'(outcome.step);
        end
    end

    assign rd_data = regs[rd_addr];
    assign stat_q  = regs[R_STAT];
    assign cause_q = regs[R_CAUSE];
    assign step_q  = regs[R_STEP];
endmodule

// File: rtl/scsi_irq_ctrl.sv
module scsi_irq_ctrl
    import scsi_cmd_pkg::*;
#(
    parameter int WIDTH = CTRL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raise,
    input  logic             wipe,
    input  logic             dma_wr_en,
    input  logic [WIDTH-1:0] dma_wr_data,
    output logic [WIDTH-1:0] dma_ctrl,
    output logic             irq
);
    logic [WIDTH-1:0] ctrl_nxt;
    logic             irq_nxt;

    always_comb begin
        ctrl_nxt = dma_ctrl;
        if (wipe)      ctrl_nxt = '0;
        if (dma_wr_en) ctrl_nxt = dma_wr_data;
        if (raise)     ctrl_nxt[DMA_PEND_BIT] = 1'b1;

        irq_nxt = irq;
        if (raise)
            irq_nxt = 1'b1;
        else if (dma_wr_en && !dma_wr_data[DMA_IEN_BIT])
            irq_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_ctrl <= '0;
            irq      <= 1'b0;
        end else begin
            dma_ctrl <= ctrl_nxt;
            irq      <= irq_nxt;
        end
    end
endmodule

// File: rtl/scsi_cmd_unit.sv
module scsi_cmd_unit
    import scsi_cmd_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int MAX_TARGET = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [REG_DATA_W-1:0] wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [REG_DATA_W-1:0] rd_data,
    input  logic [NUM_SLOTS-1:0]  dev_present,
    input  logic                  dma_wr_en,
    input  logic [CTRL_W-1:0]     dma_wr_data,
    output logic [CTRL_W-1:0]     dma_ctrl,
    output logic [2*REG_DATA_W-1:0] xfer_count,
    output logic                  irq
);
    logic            cmd_fire;
    logic [6:0]      cmd_op;
    logic [2:0]      target;
    outcome_t        outcome;
    logic [REG_DATA_W-1:0] stat_q, cause_q, step_q;

    scsi_write_bank u_wbank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmd_fire   (cmd_fire),
        .cmd_op     (cmd_op),
        .target     (target),
        .xfer_count (xfer_count)
    );

    scsi_cmd_decoder #(
        .NUM_SLOTS  (NUM_SLOTS),
        .MAX_TARGET (MAX_TARGET)
    ) u_dec (
        .fire    (cmd_fire),
        .op      (cmd_op),
        .target  (target),
        .present (dev_present),
        .outcome (outcome)
    );

    scsi_read_bank u_rbank (
        .clk     (clk),
        .rst     (rst),
        .outcome (outcome),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .stat_q  (stat_q),
        .cause_q (cause_q),
        .step_q  (step_q)
    );

    scsi_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .raise       (outcome.raise),
        .wipe        (outcome.wipe),
        .dma_wr_en   (dma_wr_en),
        .dma_wr_data (dma_wr_data),
        .dma_ctrl    (dma_ctrl),
        .irq         (irq)
    );
endmodule

// File: rtl/scsi_cmd_unit_chk.sv
module scsi_cmd_unit_chk
    import scsi_cmd_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] wr_addr,
    input logic [REG_DATA_W-1:0] wr_data,
    input logic                  dma_wr_en,
    input logic [CTRL_W-1:0]     dma_wr_data,
    input logic [CTRL_W-1:0]     dma_ctrl,
    input logic                  irq,
    input logic [REG_DATA_W-1:0] stat_q,
    input logic [REG_DATA_W-1:0] cause_q,
    input logic [REG_DATA_W-1:0] step_q
);
    logic       cmd_w;
    logic [6:0] op;
    logic       known;

    assign cmd_w = wr_en && wr_addr == W_CMD;
    assign op    = wr_data[6:0];
    assign known = op inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11,
                              7'h12, 7'h1A, 7'h42, 7'h43};

    AST_SELECT_CODES: assert property (@(posedge clk) disable iff (rst)
        cmd_w && !dma_wr_en && (op == 7'h42 || op == 7'h43) |=>
        (stat_q == 8'h91 && cause_q == 8'h18 && step_q == 8'h04) ||
        (stat_q == 8'h80 && cause_q == 8'h20 && step_q == 8'h00)); // R4

    AST_XFER_CODES: assert property (@(posedge clk) disable iff (rst)
        cmd_w && op == 7'h10 |=>
        stat_q == 8'h93 && cause_q == 8'h10 && step_q == 8'h00); // R6

    AST_CMD_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        cmd_w && op inside {7'h10, 7'h11, 7'h12, 7'h42, 7'h43} |=>
        irq && dma_ctrl[0]); // R8

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(cmd_w)); // R8

    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        dma_wr_en && !dma_wr_data[4] && !cmd_w |=> !irq); // R9

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_w && !known && !dma_wr_en |=>
        $stable(stat_q) && $stable(cause_q) && $stable(step_q) &&
        $stable(irq) && $stable(dma_ctrl)); // R11

    AST_FLUSH_CODES: assert property (@(posedge clk) disable iff (rst)
        cmd_w && op == 7'h01 && !dma_wr_en |=>
        cause_q == 8'h08 && step_q == 8'h00 && $stable(stat_q) && $stable(irq)); // R10
endmodule

bind scsi_cmd_unit scsi_cmd_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .dma_wr_en   (dma_wr_en),
    .dma_wr_data (dma_wr_data),
    .dma_ctrl    (dma_ctrl),
    .irq         (irq),
    .stat_q      (stat_q),
    .cause_q     (cause_q),
    .step_q      (step_q)
);

// File: tb/scsi_cmd_unit_tb.sv
module scsi_cmd_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  dev_present = 8'b0010_1011;
    logic        dma_wr_en = 1'b0;
    logic [31:0] dma_wr_data = '0;
    logic [31:0] dma_ctrl;
    logic [15:0] xfer_count;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    scsi_cmd_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dev_present(dev_present), .dma_wr_en(dma_wr_en),
        .dma_wr_data(dma_wr_data), .dma_ctrl(dma_ctrl),
        .xfer_count(xfer_count), .irq(irq)
    );

    // {target[2:0], opcode[7:0], stat, cause, step, irq} ; present slots 0,1,3,5
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {3'd1, 8'h42, 8'h91, 8'h18, 8'h04, 1'b1},   // R4 present
        {3'd2, 8'h42, 8'h80, 8'h20, 8'h00, 1'b1},   // R5 absent slot
        {3'd5, 8'h43, 8'h80, 8'h20, 8'h00, 1'b1},   // R5 id above 4
        {3'd3, 8'h43, 8'h91, 8'h18, 8'h04, 1'b1},   // R4 stop variant
        {3'd0, 8'h10, 8'h93, 8'h10, 8'h00, 1'b1},   // R6
        {3'd0, 8'h11, 8'h93, 8'h18, 8'h04, 1'b1},   // R7
        {3'd0, 8'h12, 8'h93, 8'h20, 8'h00, 1'b1},   // R7
        {3'd0, 8'h01, 8'h93, 8'h08, 8'h00, 1'b0},   // R10
        {3'd0, 8'h55, 8'h93, 8'h08, 8'h00, 1'b0},   // R11 undefined
        {3'd0, 8'h90, 8'h93, 8'h10, 8'h00, 1'b1},   // R3 bit 7 ignored
        {3'd0, 8'h00, 8'h93, 8'h10, 8'h00, 1'b0},   // R11 nop
        {3'd0, 8'h1A, 8'h93, 8'h10, 8'h00, 1'b0},   // R11 set attention
        {3'd0, 8'h03, 8'h93, 8'h10, 8'h00, 1'b0}    // R11 bus reset
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic dma_wr(input logic [31:0] d);
        @(negedge clk);
        dma_wr_en = 1'b1; dma_wr_data = d;
        @(negedge clk);
        dma_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check("R1 read bank", {24'b0, v}, (a == 14) ? 32'h04 : 32'h0);
        end
        check("R1 dma_ctrl", dma_ctrl, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 write bank isolation and count
        host_wr(4'h0, 8'h34);
        host_wr(4'h1, 8'h12);
        host_wr(4'h4, 8'hFF);
        check("R2 xfer_count", {16'b0, xfer_count}, 32'h1234);
        rd(4'h0, v); check("R2 rd0", {24'b0, v}, 32'h0);
        rd(4'h1, v); check("R2 rd1", {24'b0, v}, 32'h0);
        rd(4'h4, v); check("R2 rd4", {24'b0, v}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            host_wr(4'h4, {5'b0, VEC[i][35:33]});
            host_wr(4'h3, VEC[i][32:25]);
            rd(4'h4, v); check("R4-7 status", {24'b0, v}, {24'b0, VEC[i][24:17]});
            rd(4'h5, v); check("R4-7 cause",  {24'b0, v}, {24'b0, VEC[i][16:9]});
            rd(4'h6, v); check("R4-7 step",   {24'b0, v}, {24'b0, VEC[i][8:1]});
            check("R8 irq", {31'b0, irq}, {31'b0, VEC[i][0]});
            check("R8 dma pend", {31'b0, dma_ctrl[0]}, {31'b0, VEC[i][0]});
            dma_wr(32'h0);
            check("R9 irq cleared", {31'b0, irq}, 32'h0);
        end

        // R12 chip reset keeps irq, clears bank and dma_ctrl
        host_wr(4'h3, 8'h10);
        host_wr(4'h3, 8'h02);
        rd(4'h4, v); check("R12 status", {24'b0, v}, 32'h0);
        rd(4'h5, v); check("R12 cause", {24'b0, v}, 32'h0);
        rd(4'h6, v); check("R12 step", {24'b0, v}, 32'h0);
        rd(4'hE, v); check("R12 rev", {24'b0, v}, 32'h04);
        check("R12 dma_ctrl", dma_ctrl, 32'h0);
        check("R12 irq kept", {31'b0, irq}, 32'h1);

        // R9 enable bit set keeps irq; clear then drops it
        dma_wr(32'h0000_0010);
        check("R9 irq held", {31'b0, irq}, 32'h1);
        check("R9 dma load", dma_ctrl, 32'h10);
        dma_wr(32'h0000_0001);
        check("R9 irq dropped", {31'b0, irq}, 32'h0);
        check("R9 dma load2", dma_ctrl, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule